// File: doc/BRIEF.md
# Wireless Receiver Power-Path Controller

This block is the digital decision logic of a wireless-power receiver. It holds a small set of configuration fields, loaded through a synchronous write port, and combines them with comparator flags from the analog side: incoming AC power, USB supply present, over-temperature, rectified-rail over-voltage and current limit active. From these it produces the enables that steer the power stages: the bridge rectifier operating mode, the load-switch mode, the precharge source, the thermistor drive, the over-voltage clamp FET and the LDO supply source. It also produces the analog-mux select with a high-impedance indication, the current-limit enable and a set of live status bits.

Fault gating takes priority over configuration. Over-temperature shuts down every high-current path. A USB supply, unless a factory strap disables the behaviour, removes all charging paths and moves the LDO onto the USB input. Turning the load switch on waits a fixed time. Turning it off is immediate and cancels any turn-on still pending.

Top module: `wpr_power_ctl`

## Requirements
- R1: After reset every configuration field is zero. The outputs then read: rectifier asynchronous, load switch off, precharge off, thermistor drive off, clamp FET off, LDO on battery, mux high-impedance, current-limit enable high, all status bits low.
- R2: Rectifier mode encoding is 00 asynchronous, 01 half-synchronous, 10 full synchronous. When the async-allow bit (ctrl bit 0) is low, the mode is asynchronous whatever the half-sync-allow bit (ctrl bit 1) holds. With bit 0 high and bit 1 low the mode is half-synchronous. With both high it is full synchronous.
- R3: After reset the rectifier stays asynchronous until incoming AC is seen or the switch enable (ctrl bit 3) or the precharge enable (ctrl bit 4) is set. From then until the next reset, the configured mode applies even after those conditions go away.
- R4: Load-switch mode encoding is 00 off, 01 switch, 10 linear regulator. The regulator enable (ctrl bit 2) selects linear mode regardless of the switch enable. The switch enable alone selects switch mode.
- R5: The load switch shows its mode ON_CYC clock cycles after its request rises, where ON_CYC = CLK_HZ/1e6 * ON_DELAY_US. It reads off in the cycle the request falls, and a fall restarts the full wait.
- R6: The precharge output follows ctrl bit 4 unless a fault gate applies.
- R7: Thermistor code (aux bits 5:4) works as follows: 00 off, 01 on, 10 on whenever the switch enable or the precharge enable is set, 11 off.
- R8: While over-temperature is flagged, the rectifier is asynchronous and the load switch and precharge are off. The clamp FET still responds, and status bit 1 is high.
- R9: With USB present and the strap low, the load switch and precharge are off and the LDO selects USB. With the strap high, neither of those happens. In both cases status bit 2 is high, and when USB is removed the prior behaviour returns.
- R10: The clamp FET is on when the over-voltage flag is set or the force bit (ctrl bit 5) is set. Status bit 0 reflects the over-voltage flag.
- R11: Current-limit code (aux bits 3:0) 1111 drives the current-limit enable low; every other code drives it high. Status bit 3 reflects the limit-active flag.
- R12: Mux select (address 1, bits 2:0) appears on the select output. Code 000 raises the high-impedance flag, and codes 001 to 111 clear it.
- R13: Every flag passes through a two-flop synchronizer. A flag change applied between edges shows on the outputs after the second following clock edge and not after the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Field group: 0 ctrl, 1 mux, 2 aux, 3 ignored |
| cfg_wdata | input | 6 | Write data |
| ac_present_i | input | 1 | Incoming AC power flag |
| usb_present_i | input | 1 | USB supply present flag |
| over_temp_i | input | 1 | Over-temperature flag |
| pdc_ov_i | input | 1 | Rectified-rail over-voltage flag |
| ilim_active_i | input | 1 | Current limit active flag |
| usb_strap_i | input | 1 | Factory strap; high disables USB takeover |
| rect_mode_o | output | 2 | Rectifier mode |
| lsw_mode_o | output | 2 | Load-switch mode |
| pre_en_o | output | 1 | Precharge source enable |
| therm_en_o | output | 1 | Thermistor drive enable |
| ovp_fet_o | output | 1 | Over-voltage clamp FET enable |
| ldo_from_usb_o | output | 1 | LDO input select, high for USB |
| mux_sel_o | output | 3 | Analog mux select |
| mux_hiz_o | output | 1 | Mux output high-impedance |
| ilim_en_o | output | 1 | Current-limit enable |
| status_o | output | 4 | {limit, usb, over-temp, over-voltage} |

## Verification
The bench builds the block with CLK_HZ = 1 MHz and ON_DELAY_US = 20, which makes the turn-on wait 20 cycles. At that length the exact cycle of turn-on can be checked, and an enable can be dropped midway to show the cancel and restart. It also lets every table vector wait out the delay before the load-switch mode is compared. The default 100 MHz, 200 us setting uses the same counter logic, only wider.

// File: rtl/wpr_power_ctl.sv
module wpr_power_ctl #(
  parameter int unsigned CLK_HZ      = 100_000_000,
  parameter int unsigned ON_DELAY_US = 200
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_we,
  input  logic [1:0] cfg_addr,
  input  logic [5:0] cfg_wdata,
  input  logic       ac_present_i,
  input  logic       usb_present_i,
  input  logic       over_temp_i,
  input  logic       pdc_ov_i,
  input  logic       ilim_active_i,
  input  logic       usb_strap_i,
  output logic [1:0] rect_mode_o,
  output logic [1:0] lsw_mode_o,
  output logic       pre_en_o,
  output logic       therm_en_o,
  output logic       ovp_fet_o,
  output logic       ldo_from_usb_o,
  output logic [2:0] mux_sel_o,
  output logic       mux_hiz_o,
  output logic       ilim_en_o,
  output logic [3:0] status_o
);

  localparam int unsigned ON_CYC = (CLK_HZ / 1_000_000) * ON_DELAY_US;
  localparam int unsigned CNT_W  = $clog2(ON_CYC + 1);
  localparam int unsigned NFLAG  = 5;

  typedef enum logic [1:0] {RECT_ASYNC = 2'b00, RECT_HALF = 2'b01, RECT_FULL = 2'b10} rect_e;
  typedef enum logic [1:0] {LSW_OFF = 2'b00, LSW_SW = 2'b01, LSW_LIN = 2'b10} lsw_e;

  logic [5:0] ctrl_q, aux_q;
  logic [2:0] mux_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      aux_q  <= '0;
      mux_q  <= '0;
    end else if (cfg_we) begin
      case (cfg_addr)
        2'd0:    ctrl_q <= cfg_wdata;
        2'd1:    mux_q  <= cfg_wdata[2:0];
        2'd2:    aux_q  <= cfg_wdata;
        default: ;
      endcase
    end
  end

  logic unused_wdata;
  assign unused_wdata = ^cfg_wdata[5:3];

  logic async_ok, hsync_ok, top_en, sw_en, pre_bit, ovp_force;
  assign {ovp_force, pre_bit, sw_en, top_en, hsync_ok, async_ok} = ctrl_q;

  logic [1:0] therm_ctl;
  logic [3:0] ilim_code;
  assign {therm_ctl, ilim_code} = aux_q;

  logic [NFLAG-1:0] flag_raw, sync1_q, sync2_q;
  assign flag_raw = {ac_present_i, usb_present_i, over_temp_i, pdc_ov_i, ilim_active_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= '0;
      sync2_q <= '0;
    end else begin
      sync1_q <= flag_raw;
      sync2_q <= sync1_q;
    end
  end

  logic ac_s, usb_s, tsd_s, ov_s, lim_s;
  assign {ac_s, usb_s, tsd_s, ov_s, lim_s} = sync2_q;

  logic usb_take, charge_block;
  assign usb_take     = usb_s & ~usb_strap_i;
  assign charge_block = tsd_s | usb_take;

  logic armed_q, rect_go;
  assign rect_go = armed_q | ac_s | sw_en | pre_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       armed_q <= 1'b0;
    else if (rect_go) armed_q <= 1'b1;
  end

  rect_e rect_mode;
  always_comb begin
    if (!rect_go || tsd_s || !async_ok) rect_mode = RECT_ASYNC;
    else if (!hsync_ok)                 rect_mode = RECT_HALF;
    else                                rect_mode = RECT_FULL;
  end
  assign rect_mode_o = rect_mode;

  lsw_e lsw_sel;
  always_comb begin
    if (top_en)     lsw_sel = LSW_LIN;
    else if (sw_en) lsw_sel = LSW_SW;
    else            lsw_sel = LSW_OFF;
  end

  logic             lsw_req, lsw_on_q;
  logic [CNT_W-1:0] lsw_cnt_q;
  assign lsw_req = (lsw_sel != LSW_OFF) & ~charge_block;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lsw_cnt_q <= '0;
      lsw_on_q  <= 1'b0;
    end else if (!lsw_req) begin
      lsw_cnt_q <= '0;
      lsw_on_q  <= 1'b0;
    end else if (!lsw_on_q) begin
      if (lsw_cnt_q == CNT_W'(ON_CYC - 1)) lsw_on_q  <= 1'b1;
      else                                  lsw_cnt_q <= lsw_cnt_q + CNT_W'(1);
    end
  end

  assign lsw_mode_o = (lsw_req && lsw_on_q) ? lsw_sel : LSW_OFF;

  assign pre_en_o = pre_bit & ~charge_block;

  always_comb begin
    case (therm_ctl)
      2'b01:   therm_en_o = 1'b1;
      2'b10:   therm_en_o = sw_en | pre_bit;
      default: therm_en_o = 1'b0;
    endcase
  end

  assign ovp_fet_o      = ov_s | ovp_force;
  assign ldo_from_usb_o = usb_take;
  assign mux_sel_o      = mux_q;
  assign mux_hiz_o      = (mux_q == 3'b000);
  assign ilim_en_o      = (ilim_code != 4'b1111);
  assign status_o       = {lim_s, usb_s, tsd_s, ov_s};

endmodule

// File: rtl/wpr_power_ctl_chk.sv
module wpr_power_ctl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       pdc_ov_i,
  input logic       usb_strap_i,
  input logic [1:0] rect_mode_o,
  input logic [1:0] lsw_mode_o,
  input logic       pre_en_o,
  input logic       ovp_fet_o,
  input logic       ldo_from_usb_o,
  input logic [3:0] status_o,
  input logic       lsw_req,
  input logic       lsw_on_q
);

  logic [1:0] age_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             age_q <= '0;
    else if (age_q != 2'd3) age_q <= age_q + 2'd1;
  end

  assert_rect_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rect_mode_o != 2'b11);

  assert_lsw_legal_R4: assert property (@(posedge clk) disable iff (!rst_n)
    lsw_mode_o != 2'b11);

  assert_lsw_wait_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lsw_on_q) |-> $past(lsw_req));

  assert_lsw_cancel_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !lsw_req |=> !lsw_on_q);

  assert_tsd_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    status_o[1] |-> (rect_mode_o == 2'b00 && lsw_mode_o == 2'b00 && !pre_en_o));

  assert_usb_take_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o[2] && !usb_strap_i) |-> (ldo_from_usb_o && lsw_mode_o == 2'b00 && !pre_en_o));

  assert_ovp_clamp_R10: assert property (@(posedge clk) disable iff (!rst_n)
    status_o[0] |-> ovp_fet_o);

  assert_flag_sync_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q >= 2'd2) |-> (status_o[0] == $past(pdc_ov_i, 2)));

endmodule

bind wpr_power_ctl wpr_power_ctl_chk u_chk (.*);

// File: tb/wpr_power_ctl_bench.sv
module wpr_power_ctl_bench;

  localparam int unsigned ON_CYC = 20;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [1:0] cfg_addr = '0;
  logic [5:0] cfg_wdata = '0;
  logic       ac_present_i = 1'b0, usb_present_i = 1'b0, over_temp_i = 1'b0;
  logic       pdc_ov_i = 1'b0, ilim_active_i = 1'b0, usb_strap_i = 1'b0;
  logic [1:0] rect_mode_o, lsw_mode_o;
  logic       pre_en_o, therm_en_o, ovp_fet_o, ldo_from_usb_o, mux_hiz_o, ilim_en_o;
  logic [2:0] mux_sel_o;
  logic [3:0] status_o;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  wpr_power_ctl #(.CLK_HZ(1_000_000), .ON_DELAY_US(20)) u_wpr_power_ctl (.*);

  // {ctrl[5:0], aux[5:0], flags{ac,usb,tsd,ov,lim}, strap, exp{rect,lsw,pre,therm,ovp,ldo,ilim_en}}
  localparam int NV = 15;
  localparam logic [26:0] VEC [NV] = '{
    {6'b000011, 6'b000000, 5'b00000, 1'b0, 2'b10, 2'b00, 5'b00001}, // R2 full
    {6'b000001, 6'b000000, 5'b00000, 1'b0, 2'b01, 2'b00, 5'b00001}, // R2 half
    {6'b000010, 6'b000000, 5'b00000, 1'b0, 2'b00, 2'b00, 5'b00001}, // R2 async wins
    {6'b000000, 6'b000000, 5'b00000, 1'b0, 2'b00, 2'b00, 5'b00001}, // R2
    {6'b001011, 6'b100000, 5'b00000, 1'b0, 2'b10, 2'b01, 5'b01001}, // R4 switch, R7 auto
    {6'b001111, 6'b100000, 5'b00000, 1'b0, 2'b10, 2'b10, 5'b01001}, // R4 linear wins
    {6'b000111, 6'b100000, 5'b00000, 1'b0, 2'b10, 2'b10, 5'b00001}, // R4, R7 auto idle
    {6'b010011, 6'b100000, 5'b00000, 1'b0, 2'b10, 2'b00, 5'b11001}, // R6, R7
    {6'b011011, 6'b100000, 5'b00110, 1'b0, 2'b00, 2'b00, 5'b01101}, // R8 gating
    {6'b011011, 6'b100000, 5'b01000, 1'b0, 2'b10, 2'b00, 5'b01011}, // R9 takeover
    {6'b011011, 6'b100000, 5'b01000, 1'b1, 2'b10, 2'b01, 5'b11001}, // R9 strap high
    {6'b100011, 6'b000000, 5'b00000, 1'b0, 2'b10, 2'b00, 5'b00101}, // R10 force
    {6'b000011, 6'b000000, 5'b00010, 1'b0, 2'b10, 2'b00, 5'b00101}, // R10 flag
    {6'b000011, 6'b011111, 5'b00000, 1'b0, 2'b10, 2'b00, 5'b01000}, // R11 1111, R7 on
    {6'b000011, 6'b111110, 5'b00000, 1'b0, 2'b10, 2'b00, 5'b00001}  // R11, R7 reserved
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [5:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(posedge clk);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    {ac_present_i, usb_present_i, over_temp_i, pdc_ov_i, ilim_active_i, usb_strap_i} = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic settle(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog all-reqs actual=timeout expected=completion");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    do_reset();
    // R1 reset state
    chk("R1 rect", {6'd0, rect_mode_o}, 8'h00);
    chk("R1 lsw", {6'd0, lsw_mode_o}, 8'h00);
    chk("R1 misc", {2'd0, pre_en_o, therm_en_o, ovp_fet_o, ldo_from_usb_o, mux_hiz_o, ilim_en_o}, 8'h03);
    chk("R1 status", {4'd0, status_o}, 8'h00);

    // R3 arming
    wr(2'd0, 6'b000011);
    settle(5);
    chk("R3 unarmed", {6'd0, rect_mode_o}, 8'h00);
    wr(2'd0, 6'b010011);
    chk("R3 pre arms", {6'd0, rect_mode_o}, 8'h02);
    wr(2'd0, 6'b000011);
    chk("R3 sticky", {6'd0, rect_mode_o}, 8'h02);
    do_reset();
    wr(2'd0, 6'b000011);
    ac_present_i = 1'b1;
    settle(3);
    chk("R3 ac arms", {6'd0, rect_mode_o}, 8'h02);
    ac_present_i = 1'b0;
    settle(3);
    chk("R3 ac sticky", {6'd0, rect_mode_o}, 8'h02);

    // vector table
    for (int i = 0; i < NV; i++) begin
      logic [26:0] v;
      v = VEC[i];
      wr(2'd0, v[26:21]);
      wr(2'd2, v[20:15]);
      {ac_present_i, usb_present_i, over_temp_i, pdc_ov_i, ilim_active_i} = v[14:10];
      usb_strap_i = v[9];
      settle(ON_CYC + 5);
      chk($sformatf("R2 rect v%0d", i), {6'd0, rect_mode_o}, {6'd0, v[8:7]});
      chk($sformatf("R4 lsw v%0d", i), {6'd0, lsw_mode_o}, {6'd0, v[6:5]});
      chk($sformatf("R6 pre v%0d", i), {7'd0, pre_en_o}, {7'd0, v[4]});
      chk($sformatf("R7 therm v%0d", i), {7'd0, therm_en_o}, {7'd0, v[3]});
      chk($sformatf("R10 ovp v%0d", i), {7'd0, ovp_fet_o}, {7'd0, v[2]});
      chk($sformatf("R9 ldo v%0d", i), {7'd0, ldo_from_usb_o}, {7'd0, v[1]});
      chk($sformatf("R11 ilim v%0d", i), {7'd0, ilim_en_o}, {7'd0, v[0]});
    end

    // R13 synchronizer latency, R10 status
    do_reset();
    pdc_ov_i = 1'b1;
    settle(1);
    chk("R13 one edge", {7'd0, status_o[0]}, 8'h00);
    settle(1);
    chk("R13 two edges", {7'd0, status_o[0]}, 8'h01);
    chk("R10 clamp", {7'd0, ovp_fet_o}, 8'h01);
    pdc_ov_i = 1'b0;

    // R8 over-temperature with forced clamp
    wr(2'd0, 6'b111011);
    over_temp_i = 1'b1;
    settle(ON_CYC + 5);
    chk("R8 status", {7'd0, status_o[1]}, 8'h01);
    chk("R8 rect", {6'd0, rect_mode_o}, 8'h00);
    chk("R8 lsw", {6'd0, lsw_mode_o}, 8'h00);
    chk("R8 clamp alive", {7'd0, ovp_fet_o}, 8'h01);
    over_temp_i = 1'b0;
    wr(2'd0, 6'b000011);

    // R9 status in both strap settings, return to normal
    usb_strap_i = 1'b1; usb_present_i = 1'b1;
    settle(3);
    chk("R9 status strap1", {7'd0, status_o[2]}, 8'h01);
    chk("R9 ldo strap1", {7'd0, ldo_from_usb_o}, 8'h00);
    usb_strap_i = 1'b0;
    settle(1);
    chk("R9 ldo strap0", {7'd0, ldo_from_usb_o}, 8'h01);
    usb_present_i = 1'b0;
    settle(3);
    chk("R9 removed", {6'd0, status_o[2], ldo_from_usb_o}, 8'h00);

    // R11 limit status
    ilim_active_i = 1'b1;
    settle(3);
    chk("R11 status", {7'd0, status_o[3]}, 8'h01);
    ilim_active_i = 1'b0;

    // R12 mux
    wr(2'd1, 6'b000101);
    chk("R12 sel", {4'd0, mux_sel_o, mux_hiz_o}, 8'h0A);
    wr(2'd1, 6'b000111);
    chk("R12 sel7", {4'd0, mux_sel_o, mux_hiz_o}, 8'h0E);
    wr(2'd1, 6'b000000);
    chk("R12 hiz", {4'd0, mux_sel_o, mux_hiz_o}, 8'h01);

    // R5 delay, immediate off, cancel
    settle(3);
    wr(2'd0, 6'b001011);
    settle(ON_CYC - 1);
    chk("R5 before delay", {6'd0, lsw_mode_o}, 8'h00);
    settle(1);
    chk("R5 at delay", {6'd0, lsw_mode_o}, 8'h01);
    wr(2'd0, 6'b000011);
    chk("R5 immediate off", {6'd0, lsw_mode_o}, 8'h00);
    wr(2'd0, 6'b001011);
    settle(ON_CYC / 2);
    wr(2'd0, 6'b000011);
    wr(2'd0, 6'b001011);
    settle(ON_CYC - 1);
    chk("R5 cancel restart", {6'd0, lsw_mode_o}, 8'h00);
    settle(1);
    chk("R5 restart done", {6'd0, lsw_mode_o}, 8'h01);

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule